// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Comparator

This block keeps three alarm registers (minutes, hours and day of week) and compares them with the current time supplied by a separate time counter. Each alarm register carries a mask bit that takes its field out of the comparison. When a match is found, the block raises a sticky alarm flag and drives an active-low interrupt. Setting masks in a nested pattern turns the alarm into a daily, hourly or once-a-minute event.

The time counter drives the current seconds, minutes, hours and day, together with a one-cycle update strobe. The strobe marks the point at which the counter settles a new hundredth of a second. The comparison is made only on a strobe that falls in second 00 of a minute. A guard makes sure a single minute can raise the flag only once, even though the counter strobes a hundred times a second.

The alarm registers sit on the shared 8-bit register bus. Any read or write of one of them clears the flag, and with it the interrupt. Accesses to other addresses leave the flag alone.

Top module: `tod_alarm`

## Requirements
- R1: After a synchronous reset, all three alarm registers read 0x00, `alarm_flag` is 0 and `alarm_irq_n` is 1.
- R2: A write to address 3 (minutes), 5 (hours) or 7 (day) stores the byte on the clock edge. A read returns the stored byte on `bus_rdata` in the same cycle. Any other address reads 0x00 and stores nothing.
- R3: Bits 6 to 3 of the day register (address 7) always read 0, whatever was written.
- R4: On a cycle with `upd_stb` high, `now_sec` at 0x00 and every unmasked field equal, the flag is 1 after the next clock edge. Minutes compare bits 6:0, hours compare bits 6:0 (including the 12/24 and AM/PM bits), and day compares bits 2:0. Unequal unmasked fields do not set the flag.
- R5: With all mask bits (bit 7 of each register) at 0, a difference in the day alone prevents the alarm.
- R6: With only the day mask set, the alarm fires on a minutes-and-hours match on any day.
- R7: With the day and hours masks set, the alarm fires on a minutes match in any hour.
- R8: With all three masks set, the alarm fires at the first strobe of every minute (seconds 00).
- R9: Once the flag has been set in a minute, later strobes with seconds 00 do not set it again. Re-arming happens only after a strobe with seconds not equal to 00.
- R10: The flag stays set until any read or write of address 3, 5 or 7 clears it at the next edge. Accesses to other addresses do not clear it.
- R11: If an alarm match and an alarm-register access fall in the same cycle, the flag is 1 afterwards.
- R12: `alarm_irq_n` is 0 exactly when the flag is 1 and `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| int_en | input | 1 | Alarm interrupt enable |
| upd_stb | input | 1 | One-cycle strobe at the time counter's update point |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, time-register layout |
| now_day | input | 3 | Current day of week |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
An alarm match can coincide with a bus access that clears the flag. This happens in practice when software polls the alarm registers at the moment a minute turns over. The bench first clears the flag and re-arms the once-per-minute guard with a seconds-01 strobe. It then drives a read of the minutes alarm register in the same cycle as a matching seconds-00 strobe, and expects the flag to remain set afterwards. The reverse case is covered by the read that follows, which must then clear the flag.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;

    localparam int NUM_FIELDS = 3;
    localparam int FIELD_W    = 7;
    localparam int IDX_MIN    = 0;
    localparam int IDX_HOUR   = 1;
    localparam int IDX_DAY    = 2;

    typedef struct packed {
        logic               mask;
        logic [FIELD_W-1:0] val;
    } alm_reg_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } flag_act_e;

    // bits of a field that are stored and compared
    function automatic logic [FIELD_W-1:0] keep_bits(input int idx);
        return (idx == IDX_DAY) ? 7'h07 : 7'h7F;
    endfunction

endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_MIN  = 3,
    parameter int ADDR_HOUR = 5,
    parameter int ADDR_DAY  = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [FIELD_W:0]              wdata,
    output logic [FIELD_W:0]              rdata,
    output logic                          acc,
    output alm_reg_t [NUM_FIELDS-1:0]     regs
);

    logic [NUM_FIELDS-1:0] hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
        localparam int MY_ADDR = (i == IDX_MIN)  ? ADDR_MIN :
                                 (i == IDX_HOUR) ? ADDR_HOUR : ADDR_DAY;
        assign hit[i] = (addr == MY_ADDR[ADDR_W-1:0]);
    end

    assign acc = (rd | wr) & (|hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (wr && hit[i]) begin
                    regs[i].mask <= wdata[FIELD_W];
                    regs[i].val  <= wdata[FIELD_W-1:0] & keep_bits(i);
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (rd && hit[i]) rdata = regs[i];
        end
    end

    // R3
    day_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && hit[IDX_DAY]) |-> (rdata[6:3] == 4'h0));

    // R2
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(regs));

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  alm_reg_t [NUM_FIELDS-1:0]           regs,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  now_f,
    input  logic [FIELD_W-1:0]                  now_sec,
    input  logic                                upd_stb,
    output logic                                fire
);

    logic [NUM_FIELDS-1:0] field_ok;
    logic                  sec_zero;
    logic                  done_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        localparam logic [FIELD_W-1:0] KEEP = keep_bits(i);
        assign field_ok[i] = regs[i].mask |
                             ((regs[i].val & KEEP) == (now_f[i] & KEEP));
    end

    assign sec_zero = (now_sec == '0);
    assign fire     = upd_stb & sec_zero & (&field_ok) & ~done_q;

    // once-per-minute guard
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (fire) begin
            done_q <= 1'b1;
        end else if (upd_stb && !sec_zero) begin
            done_q <= 1'b0;
        end
    end

    // R9
    once_per_min_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R4
    fire_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> (upd_stb && now_sec == '0));

endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag
    import tod_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic acc,
    input  logic int_en,
    output logic flag,
    output logic irq_n
);

    flag_act_e act;

    always_comb begin
        if (fire)     act = ACT_SET;
        else if (acc) act = ACT_CLR;
        else          act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            unique case (act)
                ACT_SET: flag <= 1'b1;
                ACT_CLR: flag <= 1'b0;
                default: flag <= flag;
            endcase
        end
    end

    assign irq_n = ~(flag & int_en);

    // R4
    set_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> flag);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !fire) |=> !flag);

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc && !fire) |=> $stable(flag));

    // R12
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> irq_n);

endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ADDR_MIN  = 3,
    parameter int ADDR_HOUR = 5,
    parameter int ADDR_DAY  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              int_en,
    input  logic              upd_stb,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [6:0]        now_hour,
    input  logic [2:0]        now_day,
    output logic              alarm_flag,
    output logic              alarm_irq_n
);

    alm_reg_t [NUM_FIELDS-1:0]          regs;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_f;
    logic                               acc;
    logic                               fire;

    assign now_f[IDX_MIN]  = now_min;
    assign now_f[IDX_HOUR] = now_hour;
    assign now_f[IDX_DAY]  = {{(FIELD_W-3){1'b0}}, now_day};

    tod_alarm_regs #(
        .ADDR_W    (ADDR_W),
        .ADDR_MIN  (ADDR_MIN),
        .ADDR_HOUR (ADDR_HOUR),
        .ADDR_DAY  (ADDR_DAY)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .acc   (acc),
        .regs  (regs)
    );

    tod_alarm_match u_match (
        .clk     (clk),
        .rst     (rst),
        .regs    (regs),
        .now_f   (now_f),
        .now_sec (now_sec),
        .upd_stb (upd_stb),
        .fire    (fire)
    );

    tod_alarm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .acc    (acc),
        .int_en (int_en),
        .flag   (alarm_flag),
        .irq_n  (alarm_irq_n)
    );

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && acc) |=> alarm_flag);

endmodule

// File: tb/test_tod_alarm.sv
module test_tod_alarm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int_en = 1'b1;
    logic       upd_stb = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [6:0] now_hour = '0;
    logic [2:0] now_day = '0;
    logic       alarm_flag;
    logic       alarm_irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        int    due;
        bit    exp_flag;
        bit    exp_irqn;
        bit    chk_rd;
        byte   exp_rd;
        string tag;
    } item_t;

    item_t sb[$];

    tod_alarm i_tod_alarm (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .int_en      (int_en),
        .upd_stb     (upd_stb),
        .now_sec     (now_sec),
        .now_min     (now_min),
        .now_hour    (now_hour),
        .now_day     (now_day),
        .alarm_flag  (alarm_flag),
        .alarm_irq_n (alarm_irq_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare outputs 5 ns after the edge
    always @(posedge clk) begin
        #5;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_tests++;
            if (it.due != cyc) begin
                n_fail++;
                $display("FAIL %s: stale item due %0d at %0d", it.tag, it.due, cyc);
            end else if (alarm_flag !== it.exp_flag || alarm_irq_n !== it.exp_irqn) begin
                n_fail++;
                $display("FAIL %s: flag/irq_n=%b/%b expected %b/%b",
                         it.tag, alarm_flag, alarm_irq_n, it.exp_flag, it.exp_irqn);
            end else if (it.chk_rd && bus_rdata !== it.exp_rd) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp_rd);
            end
        end
    end

    // driver: one bus/strobe cycle, expectation sampled after the next edge
    task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                      input logic [7:0] d, input bit stb, input bit ef,
                      input bit chk, input logic [7:0] er, input string tag);
        item_t it;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; upd_stb = stb;
        it.due = cyc + 1; it.exp_flag = ef; it.exp_irqn = !(ef && int_en);
        it.chk_rd = chk; it.exp_rd = er; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; upd_stb = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d,
                          input bit ef, input string tag);
        op(1'b1, 1'b0, a, d, 1'b0, ef, 1'b0, 8'h00, tag);
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [7:0] er,
                          input bit ef, input string tag);
        op(1'b0, 1'b1, a, 8'h00, 1'b0, ef, 1'b1, er, tag);
    endtask

    task automatic strobe(input logic [6:0] s, input bit ef, input string tag);
        now_sec = s;
        op(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, ef, 1'b0, 8'h00, tag);
    endtask

    task automatic set_time(input logic [6:0] m, input logic [6:0] h,
                            input logic [2:0] dy);
        now_min = m; now_hour = h; now_day = dy;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_reg(4'd3, 8'h00, 1'b0, "R1 reset min reg");
        rd_reg(4'd7, 8'h00, 1'b0, "R1 reset day reg");
        // R2, R3 register access
        wr_reg(4'd3, 8'h30, 1'b0, "R2 wr min");
        wr_reg(4'd5, 8'h12, 1'b0, "R2 wr hour");
        wr_reg(4'd7, 8'h7B, 1'b0, "R3 wr day");
        rd_reg(4'd7, 8'h03, 1'b0, "R3 day high bits zero");
        rd_reg(4'd3, 8'h30, 1'b0, "R2 rd min");
        rd_reg(4'd5, 8'h12, 1'b0, "R2 rd hour");
        wr_reg(4'd4, 8'h55, 1'b0, "R2 wr other addr");
        rd_reg(4'd4, 8'h00, 1'b0, "R2 other addr reads 0");
        // R4 full match, R12 interrupt low
        set_time(7'h30, 7'h12, 3'd3);
        strobe(7'h00, 1'b1, "R4 full match sets flag, R12 irq low");
        strobe(7'h00, 1'b1, "R10 flag sticky");
        rd_reg(4'd3, 8'h30, 1'b0, "R10 read clears flag");
        strobe(7'h00, 1'b0, "R9 no second alarm in same minute");
        strobe(7'h01, 1'b0, "R4 seconds not 00");
        set_time(7'h31, 7'h12, 3'd3);
        strobe(7'h00, 1'b0, "R4 minutes mismatch");
        // R5 day mismatch with no masks
        set_time(7'h30, 7'h12, 3'd4);
        strobe(7'h01, 1'b0, "R5 rearm");
        strobe(7'h00, 1'b0, "R5 day mismatch blocks alarm");
        // R6 daily
        wr_reg(4'd7, 8'h83, 1'b0, "R6 set day mask");
        strobe(7'h00, 1'b1, "R6 daily alarm");
        wr_reg(4'd4, 8'h00, 1'b1, "R10 other addr write keeps flag");
        rd_reg(4'd2, 8'h00, 1'b1, "R10 other addr read keeps flag");
        wr_reg(4'd5, 8'h92, 1'b0, "R10 write clears flag");
        // R7 hourly
        set_time(7'h30, 7'h15, 3'd4);
        strobe(7'h01, 1'b0, "R7 rearm");
        strobe(7'h00, 1'b1, "R7 hourly alarm");
        rd_reg(4'd5, 8'h92, 1'b0, "R7 hour reg readback clears");
        // R8 every minute
        wr_reg(4'd3, 8'hB0, 1'b0, "R8 set minute mask");
        set_time(7'h45, 7'h08, 3'd6);
        strobe(7'h01, 1'b0, "R8 no alarm mid-minute");
        strobe(7'h00, 1'b1, "R8 per-minute alarm");
        // R12 interrupt disabled
        int_en = 1'b0;
        op(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, "R12 irq high when disabled");
        // R11 match and clearing access in the same cycle
        strobe(7'h01, 1'b1, "R11 rearm");
        rd_reg(4'd3, 8'hB0, 1'b0, "R11 clear before");
        now_sec = 7'h00;
        op(1'b0, 1'b1, 4'd3, 8'h00, 1'b1, 1'b1, 1'b1, 8'hB0, "R11 set wins over read");
        int_en = 1'b1;
        rd_reg(4'd7, 8'h83, 1'b0, "R10 day read clears");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule